// File: doc/BRIEF.md
# Tagged Instruction Sampling Unit

This unit profiles a processor by sampling single instructions instead of counting events. A down-counter, reloaded from a programmable period, steps once for every fetched instruction. When it runs out, a pseudo-random offset of 0 to 15 more fetches is drawn, and the fetch at that point becomes the one tagged instruction. The unit then follows that instruction by its tag. It records the fetch address, an instruction-cache miss flag, a branch mispredict flag, whether it trapped and with which trap code, whether it retired or was aborted, and how many cycles passed between fetch and completion.

The pipeline is outside the block. Fetch, mispredict, trap, retire and abort arrive as one-cycle strobes that carry the instruction tag. When the sampled instruction retires or is aborted, the record freezes and an interrupt is raised. Software reads the record through a small register port. It then writes an acknowledge bit, which drops the interrupt and starts a new countdown. Only one instruction is tracked at a time.

Register map (two-bit address, 32-bit data, reads return data one cycle after the read strobe): 0 = control (bit 0 enable, read/write; bit 1 acknowledge, write-one, reads 0; bit 2 sample pending, read-only), 1 = period, 2 = captured fetch address, 3 = record (bit 0 valid, bit 1 icache miss, bit 2 mispredicted, bit 3 trapped, bit 4 retired, bits 11:8 trap code, bits 27:16 delay).

Top module: `isamp_top`

## Requirements
- R1: After reset, irq is 0. Control reads 0, period reads DEF_PERIOD (64), the captured address reads 0 and the record reads 0. Read data appears on the cycle after the read strobe.
- R2: Only fetch strobes move the countdown, and idle cycles between fetches have no effect. Counting fetches from when sampling is armed (enable written with the unit idle, or an acknowledge), the tagged instruction is fetch number P+1 to P+16, where P is the period. A period of 0 acts as 1.
- R3: The offset past expiry is drawn from a free-running pseudo-random source, so repeated samples with the same period do not always tag the same fetch position.
- R4: The captured address equals the fetch address of the tagged instruction, and record bit 1 equals its fetch-time icache-miss input.
- R5: Record bit 2 is set only by a mispredict strobe whose tag matches the tracked instruction. Strobes for other tags leave it clear.
- R6: A trap strobe with a matching tag sets record bit 3 and stores its trap code in bits 11:8. A later matching trap does not replace the first code.
- R7: A matching retire strobe completes the sample with bit 4 set. Bits 27:16 then hold the number of clock edges from the fetch strobe's edge to the retire strobe's edge.
- R8: The delay saturates at 4095.
- R9: A matching abort strobe completes the sample with record bit 0 set and bit 4 clear.
- R10: irq goes high within two clock edges of completion and stays high until acknowledged.
- R11: While a sample is pending, all strobes are ignored: the record and address do not change, and fetches do not advance the countdown.
- R12: Writing control with bit 1 set while a sample is pending clears record bit 0 and control bit 2, drops irq, and rearms the countdown from the period.
- R13: With enable clear, no instruction is tagged and irq stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld | input | 1 | One instruction fetched this cycle |
| fetch_tag | input | TAG_W | Tag of the fetched instruction |
| fetch_pc | input | PC_W | Fetch address |
| fetch_icmiss | input | 1 | Fetch missed in the instruction cache |
| mispred_vld | input | 1 | Branch mispredict strobe |
| mispred_tag | input | TAG_W | Tag of the mispredicted branch |
| trap_vld | input | 1 | Trap strobe |
| trap_tag | input | TAG_W | Tag of the trapping instruction |
| trap_type | input | TT_W | Trap code |
| retire_vld | input | 1 | Retire strobe |
| retire_tag | input | TAG_W | Tag of the retiring instruction |
| abort_vld | input | 1 | Abort strobe |
| abort_tag | input | TAG_W | Tag of the aborted instruction |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Sample-complete interrupt |

## Verification
The assertions assume that the pipeline gives each instruction in flight a distinct tag, and that the tracked instruction gets exactly one completing strobe (retire or abort) after its fetch. The bench meets both conditions. It keeps every burst below the tag space, numbering fetches from zero after each arming. It then completes every fetched instruction once, in order, with mispredict and trap strobes issued before the completing strobe. It never sends events for an instruction it has not fetched.

// File: rtl/isamp_pkg.sv
package isamp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_COUNT  = 2'd1,
    PH_OFFSET = 2'd2,
    PH_HOLD   = 2'd3
  } phase_t;

  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_PERIOD = 2'd1;
  localparam logic [1:0] A_PC     = 2'd2;
  localparam logic [1:0] A_REC    = 2'd3;

  localparam int B_EN    = 0;
  localparam int B_ACK   = 1;
  localparam int B_PEND  = 2;
  localparam int R_VALID = 0;
  localparam int R_ICM   = 1;
  localparam int R_MISP  = 2;
  localparam int R_TRAP  = 3;
  localparam int R_RET   = 4;
  localparam int R_TTYPE = 8;
  localparam int R_DLY   = 16;
endpackage

// File: rtl/isamp_lfsr.sv
module isamp_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state
);
  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else     state <= state[0] ? ((state >> 1) ^ TAPS) : (state >> 1);
  end

  p_lfsr_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    state != '0);
endmodule

// File: rtl/isamp_select.sv
module isamp_select
  import isamp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int OFS_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             rearm,
  input  logic             fetch_vld,
  input  logic [CNT_W-1:0] period,
  input  logic [OFS_W-1:0] rnd,
  output logic             take
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [OFS_W-1:0] ofs;
  logic [CNT_W-1:0] load_val;

  assign load_val = (period == '0) ? ONE : period;
  assign take     = (phase == PH_OFFSET) && enable && fetch_vld && (ofs == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      ofs   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (enable) begin
            cnt   <= load_val;
            phase <= PH_COUNT;
          end
        end
        PH_COUNT: begin
          if (!enable) phase <= PH_IDLE;
          else if (fetch_vld) begin
            if (cnt == ONE) begin
              ofs   <= rnd;
              phase <= PH_OFFSET;
            end else begin
              cnt <= cnt - ONE;
            end
          end
        end
        PH_OFFSET: begin
          if (!enable) phase <= PH_IDLE;
          else if (fetch_vld) begin
            if (ofs == '0) phase <= PH_HOLD;
            else           ofs   <= ofs - OFS_W'(1);
          end
        end
        default: begin
          if (rearm) begin
            if (enable) begin
              cnt   <= load_val;
              phase <= PH_COUNT;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
      endcase
    end
  end

  p_count_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_COUNT) |-> (cnt != '0));

  p_hold_until_rearm_r11: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HOLD && !rearm) |=> (phase == PH_HOLD));
endmodule

// File: rtl/isamp_track.sv
module isamp_track #(
  parameter int TAG_W = 6,
  parameter int PC_W  = 32,
  parameter int TT_W  = 4,
  parameter int DLY_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [TAG_W-1:0] fetch_tag,
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic             fetch_icmiss,
  input  logic             mispred_vld,
  input  logic [TAG_W-1:0] mispred_tag,
  input  logic             trap_vld,
  input  logic [TAG_W-1:0] trap_tag,
  input  logic [TT_W-1:0]  trap_type,
  input  logic             retire_vld,
  input  logic [TAG_W-1:0] retire_tag,
  input  logic             abort_vld,
  input  logic [TAG_W-1:0] abort_tag,
  input  logic             rearm,
  output logic             busy,
  output logic             done,
  output logic [PC_W-1:0]  cap_pc,
  output logic             cap_icmiss,
  output logic             cap_mispred,
  output logic             cap_trapped,
  output logic [TT_W-1:0]  cap_ttype,
  output logic             cap_retired,
  output logic [DLY_W-1:0] cap_delay
);
  localparam logic [DLY_W-1:0] DLY_MAX = '1;

  logic             tracking;
  logic [TAG_W-1:0] tag_q;
  logic [DLY_W-1:0] dly;
  logic [DLY_W-1:0] dly_next;
  logic             hit_mis, hit_trap, hit_ret, hit_abt;

  assign hit_mis  = mispred_vld && (mispred_tag == tag_q);
  assign hit_trap = trap_vld    && (trap_tag    == tag_q);
  assign hit_ret  = retire_vld  && (retire_tag  == tag_q);
  assign hit_abt  = abort_vld   && (abort_tag   == tag_q);
  assign dly_next = (dly == DLY_MAX) ? DLY_MAX : dly + DLY_W'(1);
  assign busy     = tracking || done;

  always_ff @(posedge clk) begin
    if (rst) begin
      tracking    <= 1'b0;
      done        <= 1'b0;
      tag_q       <= '0;
      dly         <= '0;
      cap_pc      <= '0;
      cap_icmiss  <= 1'b0;
      cap_mispred <= 1'b0;
      cap_trapped <= 1'b0;
      cap_ttype   <= '0;
      cap_retired <= 1'b0;
      cap_delay   <= '0;
    end else if (take) begin
      tracking    <= 1'b1;
      done        <= 1'b0;
      tag_q       <= fetch_tag;
      dly         <= '0;
      cap_pc      <= fetch_pc;
      cap_icmiss  <= fetch_icmiss;
      cap_mispred <= 1'b0;
      cap_trapped <= 1'b0;
      cap_ttype   <= '0;
      cap_retired <= 1'b0;
      cap_delay   <= '0;
    end else if (tracking) begin
      if (hit_mis) cap_mispred <= 1'b1;
      if (hit_trap && !cap_trapped) begin
        cap_trapped <= 1'b1;
        cap_ttype   <= trap_type;
      end
      if (hit_ret || hit_abt) begin
        tracking    <= 1'b0;
        done        <= 1'b1;
        cap_retired <= hit_ret;
        cap_delay   <= dly_next;
      end else begin
        dly <= dly_next;
      end
    end else if (rearm) begin
      done <= 1'b0;
    end
  end

  p_take_when_free_r11: assert property (@(posedge clk) disable iff (rst)
    take |-> !busy);

  p_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    (done && !rearm) |=> (done && $stable(cap_pc) && $stable(cap_delay) &&
                          $stable(cap_retired) && $stable(cap_ttype) &&
                          $stable(cap_mispred) && $stable(cap_trapped)));

  p_retire_completes_r7: assert property (@(posedge clk) disable iff (rst)
    (tracking && hit_ret) |=> (done && cap_retired));
endmodule

// File: rtl/isamp_regs.sv
module isamp_regs
  import isamp_pkg::*;
#(
  parameter int               DATA_W     = 32,
  parameter int               PC_W       = 32,
  parameter int               CNT_W      = 16,
  parameter int               TT_W       = 4,
  parameter int               DLY_W      = 12,
  parameter logic [CNT_W-1:0] DEF_PERIOD = 16'd64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              enable,
  output logic [CNT_W-1:0]  period,
  output logic              rearm,
  input  logic              done,
  input  logic [PC_W-1:0]   cap_pc,
  input  logic              cap_icmiss,
  input  logic              cap_mispred,
  input  logic              cap_trapped,
  input  logic [TT_W-1:0]   cap_ttype,
  input  logic              cap_retired,
  input  logic [DLY_W-1:0]  cap_delay
);
  logic              wr_ctrl;
  logic [DATA_W-1:0] rec_word;
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] rd_mux;

  assign wr_ctrl = reg_wr_en && (reg_addr == A_CTRL);
  assign rearm   = wr_ctrl && reg_wdata[B_ACK] && done;

  always_comb begin
    rec_word                   = '0;
    rec_word[R_VALID]          = done;
    rec_word[R_ICM]            = cap_icmiss;
    rec_word[R_MISP]           = cap_mispred;
    rec_word[R_TRAP]           = cap_trapped;
    rec_word[R_RET]            = cap_retired;
    rec_word[R_TTYPE +: TT_W]  = cap_ttype;
    rec_word[R_DLY +: DLY_W]   = cap_delay;
    ctrl_word                  = '0;
    ctrl_word[B_EN]            = enable;
    ctrl_word[B_PEND]          = done;
    case (reg_addr)
      A_CTRL:   rd_mux = ctrl_word;
      A_PERIOD: rd_mux = DATA_W'(period);
      A_PC:     rd_mux = DATA_W'(cap_pc);
      default:  rd_mux = rec_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable    <= 1'b0;
      period    <= DEF_PERIOD;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      irq <= done;
      if (wr_ctrl) enable <= reg_wdata[B_EN];
      if (reg_wr_en && reg_addr == A_PERIOD) period <= reg_wdata[CNT_W-1:0];
      if (reg_rd_en) reg_rdata <= rd_mux;
    end
  end

  p_irq_drops_after_ack_r12: assert property (@(posedge clk) disable iff (rst)
    rearm |=> ##1 !irq);
endmodule

// File: rtl/isamp_top.sv
module isamp_top
  import isamp_pkg::*;
#(
  parameter int               TAG_W      = 6,
  parameter int               PC_W       = 32,
  parameter int               TT_W       = 4,
  parameter int               DLY_W      = 12,
  parameter int               CNT_W      = 16,
  parameter int               OFS_W      = 4,
  parameter int               LFSR_W     = 16,
  parameter int               DATA_W     = 32,
  parameter logic [CNT_W-1:0] DEF_PERIOD = 16'd64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_vld,
  input  logic [TAG_W-1:0]  fetch_tag,
  input  logic [PC_W-1:0]   fetch_pc,
  input  logic              fetch_icmiss,
  input  logic              mispred_vld,
  input  logic [TAG_W-1:0]  mispred_tag,
  input  logic              trap_vld,
  input  logic [TAG_W-1:0]  trap_tag,
  input  logic [TT_W-1:0]   trap_type,
  input  logic              retire_vld,
  input  logic [TAG_W-1:0]  retire_tag,
  input  logic              abort_vld,
  input  logic [TAG_W-1:0]  abort_tag,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [LFSR_W-1:0] lfsr;
  logic              enable, rearm, take, busy, done;
  logic [CNT_W-1:0]  period;
  logic [PC_W-1:0]   cap_pc;
  logic              cap_icmiss, cap_mispred, cap_trapped, cap_retired;
  logic [TT_W-1:0]   cap_ttype;
  logic [DLY_W-1:0]  cap_delay;

  isamp_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk(clk), .rst(rst), .state(lfsr)
  );

  isamp_select #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_sel (
    .clk(clk), .rst(rst), .enable(enable), .rearm(rearm),
    .fetch_vld(fetch_vld), .period(period), .rnd(lfsr[OFS_W-1:0]),
    .take(take)
  );

  isamp_track #(.TAG_W(TAG_W), .PC_W(PC_W), .TT_W(TT_W), .DLY_W(DLY_W)) u_trk (
    .clk(clk), .rst(rst), .take(take),
    .fetch_tag(fetch_tag), .fetch_pc(fetch_pc), .fetch_icmiss(fetch_icmiss),
    .mispred_vld(mispred_vld), .mispred_tag(mispred_tag),
    .trap_vld(trap_vld), .trap_tag(trap_tag), .trap_type(trap_type),
    .retire_vld(retire_vld), .retire_tag(retire_tag),
    .abort_vld(abort_vld), .abort_tag(abort_tag),
    .rearm(rearm), .busy(busy), .done(done),
    .cap_pc(cap_pc), .cap_icmiss(cap_icmiss), .cap_mispred(cap_mispred),
    .cap_trapped(cap_trapped), .cap_ttype(cap_ttype),
    .cap_retired(cap_retired), .cap_delay(cap_delay)
  );

  isamp_regs #(.DATA_W(DATA_W), .PC_W(PC_W), .CNT_W(CNT_W), .TT_W(TT_W),
               .DLY_W(DLY_W), .DEF_PERIOD(DEF_PERIOD)) u_regs (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .enable(enable), .period(period), .rearm(rearm),
    .done(done), .cap_pc(cap_pc), .cap_icmiss(cap_icmiss),
    .cap_mispred(cap_mispred), .cap_trapped(cap_trapped),
    .cap_ttype(cap_ttype), .cap_retired(cap_retired), .cap_delay(cap_delay)
  );

  p_busy_blocks_take_r11: assert property (@(posedge clk) disable iff (rst)
    busy |-> !take);
endmodule

// File: tb/isamp_top_tb_top.sv
module isamp_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_vld = 0, fetch_icmiss = 0;
  logic [5:0]  fetch_tag = 0, mispred_tag = 0, trap_tag = 0, retire_tag = 0, abort_tag = 0;
  logic [31:0] fetch_pc = 0;
  logic        mispred_vld = 0, trap_vld = 0, retire_vld = 0, abort_vld = 0;
  logic [3:0]  trap_type = 0;
  logic        reg_wr_en = 0, reg_rd_en = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int cf [64];
  int cr [64];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  isamp_top dut_i (
    .clk(clk), .rst(rst), .fetch_vld(fetch_vld), .fetch_tag(fetch_tag),
    .fetch_pc(fetch_pc), .fetch_icmiss(fetch_icmiss),
    .mispred_vld(mispred_vld), .mispred_tag(mispred_tag),
    .trap_vld(trap_vld), .trap_tag(trap_tag), .trap_type(trap_type),
    .retire_vld(retire_vld), .retire_tag(retire_tag),
    .abort_vld(abort_vld), .abort_tag(abort_tag),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected < 150000)", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 0;
    d = reg_rdata;
  endtask

  function automatic bit a_icm(input int i);  return (i % 3) == 0; endfunction
  function automatic bit a_mis(input int m, input int i); return m == 1 || (m == 0 && (i % 4) == 1); endfunction
  function automatic bit a_trp(input int m, input int i); return m == 1 || (m == 0 && (i % 5) == 2); endfunction
  function automatic bit a_abt(input int m, input int i); return m == 1 || (m == 0 && (i % 7) == 3); endfunction

  // Arms sampling, streams p+16 fetches, then completes every instruction.
  task automatic run_sample(input int p, input int gap, input bit sat, input int mode,
                            output int k);
    logic [31:0] v;
    int n, exp_dly;
    n = p + 16;
    wr(2'd1, p);
    wr(2'd0, 32'h3);
    idle(2);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fetch_vld = 1; fetch_tag = i[5:0]; fetch_pc = 32'h1000 + 4 * i;
      fetch_icmiss = a_icm(i); cf[i] = cyc;
      @(negedge clk);
      fetch_vld = 0;
      if (gap > 0) idle(gap - 1);
    end
    if (sat) idle(4200);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mispred_vld = a_mis(mode, i); mispred_tag = i[5:0];
      trap_vld = a_trp(mode, i); trap_tag = i[5:0]; trap_type = 4'(i % 16);
      @(negedge clk);
      mispred_vld = 0;
      trap_vld = a_trp(mode, i); trap_type = 4'((i + 7) % 16);
      @(negedge clk);
      trap_vld = 0;
      if (a_abt(mode, i)) begin abort_vld = 1; abort_tag = i[5:0]; end
      else begin retire_vld = 1; retire_tag = i[5:0]; end
      cr[i] = cyc;
      @(negedge clk);
      abort_vld = 0; retire_vld = 0;
    end
    idle(3);
    check("R10 irq after completion", irq, 1);
    rd(2'd2, v);
    k = (int'(v) - 32'h1000) / 4;
    checks++;
    if (k < p || k > p + 15) begin
      fails++;
      $display("FAIL R2 tagged fetch index: actual %0d expected %0d..%0d", k + 1, p + 1, p + 16);
      k = p;
    end
    rd(2'd3, v);
    exp_dly = cr[k] - cf[k];
    if (exp_dly > 4095) exp_dly = 4095;
    check("R9 record valid", v[0], 1);
    check("R4 icache miss flag", v[1], a_icm(k));
    check("R5 mispredict flag", v[2], a_mis(mode, k));
    check("R6 trapped flag", v[3], a_trp(mode, k));
    check("R6 first trap code", v[11:8], a_trp(mode, k) ? 4'(k % 16) : 4'd0);
    check("R7 R9 retired flag", v[4], !a_abt(mode, k));
    check(sat ? "R8 saturated delay" : "R7 delay", v[27:16], exp_dly);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    check("R1 irq at reset", irq, 0);
    rd(2'd0, v); check("R1 control reset", v, 0);
    rd(2'd1, v); check("R1 period reset", v, 64);
    rd(2'd2, v); check("R1 address reset", v, 0);
    rd(2'd3, v); check("R1 record reset", v, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      fetch_vld = 1; fetch_tag = 6'(i); fetch_pc = 32'h8000 + 4 * i;
      @(negedge clk);
      fetch_vld = 0; retire_vld = 1; retire_tag = 6'(i);
      @(negedge clk);
      retire_vld = 0;
    end
    idle(3);
    check("R13 no irq while disabled", irq, 0);
    rd(2'd3, v); check("R13 no record while disabled", v, 0);
  endtask

  task automatic t_basic();
    int k;
    run_sample(8, 1, 0, 0, k);
    run_sample(12, 1, 0, 2, k);
  endtask

  task automatic t_gapped();
    int k;
    run_sample(10, 4, 0, 0, k);
  endtask

  task automatic t_abort_and_traps();
    int k;
    run_sample(5, 1, 0, 1, k);
  endtask

  task automatic t_saturate();
    int k;
    run_sample(3, 1, 1, 2, k);
  endtask

  task automatic t_frozen();
    logic [31:0] before_rec, before_pc, v;
    int k;
    run_sample(6, 1, 0, 2, k);
    rd(2'd3, before_rec);
    rd(2'd2, before_pc);
    @(negedge clk);
    trap_vld = 1; trap_tag = 6'(k); trap_type = 4'hA;
    mispred_vld = 1; mispred_tag = 6'(k);
    @(negedge clk);
    trap_vld = 0; mispred_vld = 0; abort_vld = 1; abort_tag = 6'(k);
    @(negedge clk);
    abort_vld = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); fetch_vld = 1; fetch_tag = 6'(i); fetch_pc = 32'h9000;
      @(negedge clk); fetch_vld = 0;
    end
    idle(2);
    rd(2'd3, v); check("R11 record frozen", v, before_rec);
    rd(2'd2, v); check("R11 address frozen", v, before_pc);
    check("R11 irq held", irq, 1);
    // next sample window shows the pending-time fetches were not counted
    run_sample(9, 1, 0, 0, k);
  endtask

  task automatic t_ack();
    logic [31:0] v;
    wr(2'd0, 32'h2);
    idle(2);
    check("R12 irq cleared by ack", irq, 0);
    rd(2'd3, v); check("R12 record valid cleared", v[0], 0);
    rd(2'd0, v); check("R12 pending bit cleared", v[2], 0);
  endtask

  task automatic t_offsets();
    int k, first, distinct;
    distinct = 0;
    for (int s = 0; s < 6; s++) begin
      idle(s * 3 + 1);
      run_sample(4, 1, 0, 2, k);
      if (s == 0) first = k;
      else if (k != first) distinct = 1;
    end
    check("R3 offsets vary across samples", distinct, 1);
  endtask

  initial begin
    idle(3);
    rst = 0;
    idle(2);
    t_reset_state();
    t_disabled();
    t_basic();
    t_gapped();
    t_abort_and_traps();
    t_saturate();
    t_frozen();
    t_ack();
    t_offsets();
    idle(5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule